// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

The controller joins two eight-input priority units into one interrupt source for a processor. The secondary unit serves lines 8 to 15. Its combined request enters the primary unit at slot 2, so 15 of the 16 line numbers are usable. A request driven on the reserved number 2 is moved onto line 9, so older software that expects line 2 still gets service. Every line has a fixed rank. Line 0 ranks highest. Lines 8 to 15 share the rank of primary slot 2 and are ordered lowest number first among themselves.

A 16-bit mask register is loaded through a simple write port, and a set bit silences its line. When an unmasked request outranks everything in service, `irq_o` rises. The processor then pulses `ack_i`. The controller latches an 8-bit vector, equal to a programmable base plus the winning line number, and marks that line in service. A line in service blocks requests of equal or lower rank, while a request of higher rank can still preempt it. An end-of-interrupt pulse retires the highest-ranked line that is in service.

Requests are level-sensitive only. Every request is sampled combinationally by the priority logic.

Top module: `pic_cascade_ctrl`

## Requirements
- R1: After reset, all 16 mask bits are set, nothing is in service, the vector base is 0, `vector_o` is 0, and `irq_o` stays low whatever `req_i` carries.
- R2: A cycle with `mask_we_i` high loads `mask_i` into the mask. Mask bit n (n not 2) silences line n. Mask bit 2 silences the whole secondary unit (lines 8 to 15).
- R3: With nothing in service, `irq_o` is high whenever an unmasked request exists. The winner is chosen in the rank order 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.
- R4: `req_i[2]` acts as a request on line 9. It is gated by mask bit 9 (and by mask bit 2, as for any secondary line), and it is acknowledged with the vector of line 9.
- R5: A cycle with `ack_i` and `irq_o` both high makes `vector_o` equal (base + winning line) mod 256 from the next cycle on, and marks the winner in service.
- R6: A cycle with `ack_i` high while `irq_o` is low leaves `vector_o` and the in-service state unchanged.
- R7: While a line is in service, requests of equal or lower rank keep `irq_o` low.
- R8: A request that outranks every line in service raises `irq_o`. This includes a secondary line preempting a lower-ranked secondary line that is in service.
- R9: A cycle with `eoi_i` high retires the highest-ranked line in service. For a secondary line it clears that line and clears the primary slot 2 only if no other secondary line remains in service.
- R10: A cycle with `base_we_i` high loads `base_i` as the vector base. This affects later acknowledges only and leaves the current `vector_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Level request per line; bit 2 is moved to line 9 |
| mask_we_i | input | 1 | Mask write strobe |
| mask_i | input | 16 | Mask write data, 1 = silenced |
| base_we_i | input | 1 | Vector base write strobe |
| base_i | input | 8 | Vector base write data |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| eoi_i | input | 1 | End-of-interrupt pulse |
| irq_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Vector latched at the last accepted acknowledge |

## Verification
A lost in-service bit shows up at `irq_o` in the same cycle: a request that should be blocked becomes visible. A stuck in-service bit shows up the same way, as a request that should be taken stays hidden. For this reason the bench holds competing requests across each acknowledge and end-of-interrupt. A cascade bit that does not track the secondary unit becomes visible after the first end-of-interrupt for a nested secondary line: a pending primary line of lower rank then leaks through. A wrong rank or a wrong alias route is seen one cycle after the acknowledge, in `vector_o`.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int UNIT_N       = 8;
  localparam int IDX_W        = $clog2(UNIT_N);
  localparam int LINE_N       = 2 * UNIT_N;
  localparam int LINE_W       = $clog2(LINE_N);
  localparam int VEC_W        = 8;
  localparam int CASCADE_SLOT = 2;
  localparam int ALIAS_LINE   = 9;

  // index of the lowest set bit (highest rank); 0 when empty
  function automatic logic [IDX_W-1:0] first_set(input logic [UNIT_N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = UNIT_N - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [UNIT_N-1:0] bit_of(input logic [IDX_W-1:0] idx);
    return UNIT_N'(1) << idx;
  endfunction

  // full line number from the two unit winners
  function automatic logic [LINE_W-1:0] line_of(input logic cas,
                                                input logic [IDX_W-1:0] p,
                                                input logic [IDX_W-1:0] s);
    return cas ? LINE_W'(UNIT_N) + LINE_W'(s) : LINE_W'(p);
  endfunction

  function automatic logic [VEC_W-1:0] vector_of(input logic [VEC_W-1:0] base,
                                                 input logic [LINE_W-1:0] line);
    return base + VEC_W'(line);
  endfunction
endpackage

// File: rtl/pic_req_map.sv
module pic_req_map
  import pic_pkg::*;
(
  input  logic [LINE_N-1:0] req_i,
  input  logic [LINE_N-1:0] mask_i,
  input  logic              casc_i,
  output logic [UNIT_N-1:0] prim_req_o,
  output logic [UNIT_N-1:0] sec_req_o
);
  for (genvar g = 0; g < LINE_N; g++) begin : g_line
    if (g == CASCADE_SLOT) begin : g_casc
      assign prim_req_o[g] = casc_i & ~mask_i[g];
    end else if (g < UNIT_N) begin : g_prim
      assign prim_req_o[g] = req_i[g] & ~mask_i[g];
    end else if (g == ALIAS_LINE) begin : g_alias
      assign sec_req_o[g-UNIT_N] = (req_i[g] | req_i[CASCADE_SLOT]) & ~mask_i[g];
    end else begin : g_sec
      assign sec_req_o[g-UNIT_N] = req_i[g] & ~mask_i[g];
    end
  end
endmodule

// File: rtl/pic_prio_unit.sv
module pic_prio_unit
  import pic_pkg::*;
#(
  parameter int NEST_SLOT = UNIT_N  // slot that may re-enter while in service
) (
  input  logic [UNIT_N-1:0] req_i,
  input  logic [UNIT_N-1:0] isr_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  win_o
);
  logic [IDX_W-1:0] top;
  logic             nest_ok;

  assign win_o   = first_set(req_i);
  assign top     = first_set(isr_i);
  assign nest_ok = (win_o == top) && (int'(win_o) == NEST_SLOT);
  assign irq_o   = (|req_i) && (!(|isr_i) || (win_o < top) || nest_ok);

  always_comb begin
    if (irq_o && (int'(win_o) != NEST_SLOT))
      p_winner_free_r7: assert (!isr_i[win_o]);
  end
endmodule

// File: rtl/pic_cascade_ctrl.sv
module pic_cascade_ctrl
  import pic_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LINE_N-1:0]   req_i,
  input  logic                mask_we_i,
  input  logic [LINE_N-1:0]   mask_i,
  input  logic                base_we_i,
  input  logic [VEC_W-1:0]    base_i,
  input  logic                ack_i,
  input  logic                eoi_i,
  output logic                irq_o,
  output logic [VEC_W-1:0]    vector_o
);
  logic [LINE_N-1:0] mask_q;
  logic [VEC_W-1:0]  base_q, vec_q;
  logic [UNIT_N-1:0] pisr_q, sisr_q;
  logic [UNIT_N-1:0] prim_req, sec_req;
  logic              s_irq, p_irq;
  logic [IDX_W-1:0]  s_win, p_win, p_top, s_top;

  // named internal events
  logic              ack_take, take_cas, eoi_hit, eoi_cas;
  logic [UNIT_N-1:0] p_set, s_set, p_clr, s_clr, s_left;

  pic_req_map u_map (
    .req_i(req_i), .mask_i(mask_q), .casc_i(s_irq),
    .prim_req_o(prim_req), .sec_req_o(sec_req)
  );

  pic_prio_unit #(.NEST_SLOT(UNIT_N)) u_sec (
    .req_i(sec_req), .isr_i(sisr_q), .irq_o(s_irq), .win_o(s_win)
  );

  pic_prio_unit #(.NEST_SLOT(CASCADE_SLOT)) u_prim (
    .req_i(prim_req), .isr_i(pisr_q), .irq_o(p_irq), .win_o(p_win)
  );

  assign irq_o    = p_irq;
  assign vector_o = vec_q;

  assign ack_take = ack_i & p_irq;
  assign take_cas = int'(p_win) == CASCADE_SLOT;
  assign p_set    = ack_take ? bit_of(p_win) : '0;
  assign s_set    = (ack_take && take_cas) ? bit_of(s_win) : '0;

  assign p_top    = first_set(pisr_q);
  assign s_top    = first_set(sisr_q);
  assign eoi_hit  = eoi_i & (|pisr_q);
  assign eoi_cas  = eoi_hit && (int'(p_top) == CASCADE_SLOT);
  assign s_clr    = eoi_cas ? bit_of(s_top) : '0;
  assign s_left   = sisr_q & ~s_clr;
  assign p_clr    = (eoi_hit && (!eoi_cas || s_left == '0)) ? bit_of(p_top) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      base_q <= '0;
      vec_q  <= '0;
      pisr_q <= '0;
      sisr_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= mask_i;
      if (base_we_i) base_q <= base_i;
      if (ack_take)  vec_q  <= vector_of(base_q, line_of(take_cas, p_win, s_win));
      pisr_q <= (pisr_q & ~p_clr) | p_set;
      sisr_q <= (sisr_q & ~s_clr) | s_set;
    end
  end

  p_cascade_tracks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pisr_q[CASCADE_SLOT] == (|sisr_q));

  p_vector_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && irq_o) |=> $stable(vector_o));

  p_grow_on_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> (((pisr_q & ~$past(pisr_q)) == '0) && ((sisr_q & ~$past(sisr_q)) == '0)));

  p_eoi_retires_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && (|pisr_q)) |=>
      ($countones({pisr_q, sisr_q}) < $past($countones({pisr_q, sisr_q}))));

  p_all_masked_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);
endmodule

// File: tb/pic_cascade_ctrl_test.sv
module pic_cascade_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] req = '0;
  logic        mask_we = 0;
  logic [15:0] mask_d = '0;
  logic        base_we = 0;
  logic [7:0]  base_d = '0;
  logic        ack = 0;
  logic        eoi = 0;
  logic        irq;
  logic [7:0]  vec;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pic_cascade_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .mask_we_i(mask_we), .mask_i(mask_d),
    .base_we_i(base_we), .base_i(base_d),
    .ack_i(ack), .eoi_i(eoi), .irq_o(irq), .vector_o(vec)
  );

  // {mask, req, expect irq, expected line}
  localparam logic [36:0] TBL [12] = '{
    {16'hFFFF, 16'hFFFF, 1'b0, 4'd0},
    {16'h0000, 16'h0020, 1'b1, 4'd5},
    {16'h0000, 16'h0028, 1'b1, 4'd3},
    {16'h0000, 16'h1008, 1'b1, 4'd12},
    {16'h0000, 16'h1400, 1'b1, 4'd10},
    {16'h0000, 16'h0102, 1'b1, 4'd1},
    {16'h0000, 16'h0004, 1'b1, 4'd9},
    {16'h0200, 16'h0004, 1'b0, 4'd0},
    {16'h0004, 16'h0004, 1'b0, 4'd0},
    {16'h0008, 16'h0088, 1'b1, 4'd7},
    {16'h0000, 16'h8000, 1'b1, 4'd15},
    {16'h0004, 16'h1020, 1'b1, 4'd5}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_mask(input logic [15:0] m);
    @(negedge clk); mask_we = 1; mask_d = m;
    @(negedge clk); mask_we = 0; #1;
  endtask

  task automatic write_base(input logic [7:0] b);
    @(negedge clk); base_we = 1; base_d = b;
    @(negedge clk); base_we = 0; #1;
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0; #1;
  endtask

  task automatic pulse_eoi;
    @(negedge clk); eoi = 1;
    @(negedge clk); eoi = 0; #1;
  endtask

  task automatic set_req(input logic [15:0] r);
    @(negedge clk); req = r; #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 irq after reset", int'(irq), 0);
    check("R1 vector after reset", int'(vec), 0);
    set_req(16'hFFFF);
    check("R1 reset mask silences all", int'(irq), 0);
    set_req(16'h0000);
    write_base(8'h40);
    check("R10 base write keeps vector", int'(vec), 0);

    // table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < 12; i++) begin
      logic [36:0] e;
      e = TBL[i];
      write_mask(e[36:21]);
      set_req(e[20:5]);
      check($sformatf("R3 irq entry %0d", i), int'(irq), int'(e[4]));
      if (e[4]) begin
        pulse_ack();
        check($sformatf("R5 vector entry %0d", i), int'(vec), 8'h40 + int'(e[3:0]));
        check($sformatf("R7 blocked entry %0d", i), int'(irq), 0);
        set_req(16'h0000);
        pulse_eoi();
      end
    end

    // nesting and preemption: R7 R8 R9
    write_mask(16'h0000);
    set_req(16'h1000);
    check("R3 line 12 raises", int'(irq), 1);
    pulse_ack();
    check("R5 line 12 vector", int'(vec), 8'h4C);
    set_req(16'h1020);
    check("R7 line 5 below cascade", int'(irq), 0);
    set_req(16'h1220);
    check("R8 line 9 preempts 12", int'(irq), 1);
    pulse_ack();
    check("R8 line 9 vector", int'(vec), 8'h49);
    set_req(16'h1221);
    check("R8 line 0 preempts", int'(irq), 1);
    pulse_ack();
    check("R8 line 0 vector", int'(vec), 8'h40);
    pulse_eoi();
    check("R9 line 0 retired", int'(irq), 1);
    set_req(16'h1020);
    check("R7 nested blocks", int'(irq), 0);
    pulse_eoi();
    check("R9 cascade kept while 12 in service", int'(irq), 0);
    pulse_eoi();
    check("R9 cascade cleared with 12", int'(irq), 1);
    pulse_ack();
    check("R9 line 12 retaken", int'(vec), 8'h4C);
    set_req(16'h0000);
    pulse_eoi();

    // R6: acknowledge with nothing pending
    check("R6 idle irq", int'(irq), 0);
    pulse_ack();
    check("R6 vector unchanged", int'(vec), 8'h4C);
    set_req(16'h0080);
    check("R6 state intact", int'(irq), 1);
    pulse_ack();
    check("R6 line 7 vector", int'(vec), 8'h47);
    set_req(16'h0000);
    pulse_eoi();

    // R10: base change and wrap
    write_base(8'hF8);
    check("R10 vector held on base write", int'(vec), 8'h47);
    set_req(16'h0400);
    pulse_ack();
    check("R10 wrapped vector", int'(vec), 8'h02);
    set_req(16'h0000);
    pulse_eoi();

    // R9 on primary lines
    set_req(16'h0040);
    pulse_ack();
    check("R5 line 6 vector", int'(vec), 8'hFE);
    set_req(16'h0050);
    check("R8 line 4 preempts 6", int'(irq), 1);
    pulse_ack();
    check("R7 both in service", int'(irq), 0);
    pulse_eoi();
    check("R9 line 4 retired first", int'(irq), 1);
    set_req(16'h0000);
    pulse_eoi();
    pulse_eoi();
    set_req(16'h0040);
    check("R9 all retired", int'(irq), 1);
    set_req(16'h0000);

    finish_run();
  end
endmodule